// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block watches the control strobes of an asynchronous DRAM that has one row strobe and two byte column strobes (lower lane, upper lane), all active low. It samples them on a system clock and works out, one clock after each sample, what kind of memory cycle is in progress. It also produces per-lane output-enable and write-enable controls, the latched row and column addresses, and a pulse naming each row that has just been refreshed. It serves as the control half of a behavioural device model or as a protocol checker placed beside a DRAM controller.

Both column strobes feed one internal column strobe. That strobe goes active when the first lane strobe falls and goes inactive only when the last one rises. The order of the row and column strobe edges picks the refresh flavour. A row strobe falling with no column strobe low opens a row, or performs a row-only refresh. A row strobe falling with a column strobe already low is a column-first refresh that takes its row from an internal wrapping counter. A column strobe held low from an access across a row-strobe pulse is a hidden refresh, during which the read data stays driven.

Top module: `dcasDecoder`

## Requirements
- R1: `cycleType` is one-hot with bit indices standby=0, word read=1, byte read=2, word write=3, byte write=4, read-write=5, hidden refresh=6, row-only=7, column-first refresh=8. Reset leaves it at standby with all lane controls and flags low.
- R2: Every output reflects the strobes sampled at the previous rising clock edge. The row strobe high and both column strobes high give standby, with `laneOe` and `laneWe` both zero.
- R3: An open row with a column strobe low, write enable high and output enable low is a read. `laneOe` bit 0 follows the lower strobe and bit 1 the upper. Both strobes low give word read; one low gives byte read. Output enable high keeps the type but clears `laneOe`.
- R4: An open row with a column strobe low and write enable low at the column fall is an early write. `laneWe` is set for each lane whose strobe is low, and `laneOe` stays zero whatever output enable does.
- R5: The column address is latched only when the internal column strobe goes active. A second lane strobe falling while the first is low latches nothing new. The access continues as a byte access while either strobe is still low.
- R6: A row-strobe fall with both column strobes high latches `rowAddr`, gives the row-only type, and pulses `refStb` for one cycle with `refRow` equal to the address. The row-only type also covers an open row with no column strobe low.
- R7: A row-strobe fall with a column strobe low, and no access held, is a column-first refresh. `refStb` pulses with `refRow` equal to the counter, which starts at 0 and then advances by one. Neither address register changes, and both lane controls stay zero. A column strobe low while the row strobe is high and no access is held also reports this type.
- R8: When a read access keeps its column strobe low across a row-strobe rise and a new fall, the type is hidden refresh and `laneOe` stays driven. The refresh row comes from the counter, and the address registers keep the access's values.
- R9: Write enable falling during a read access (high at the column fall) gives read-write, with `laneWe` set and `laneOe` clear, until the next column fall.
- R10: `protoErr` pulses for one cycle when the internal column strobe goes inactive during an access. It fires if the row strobe has been sampled low on fewer than `MIN_RAS_ACT` consecutive samples, the current one included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasN | input | 1 | Row strobe, active low |
| casLoN | input | 1 | Lower-lane column strobe, active low |
| casHiN | input | 1 | Upper-lane column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cycleType | output | 9 | One-hot cycle classification |
| laneOe | output | 2 | Per-lane output drive enable |
| laneWe | output | 2 | Per-lane write enable |
| rowAddr | output | ADDR_W | Latched row address |
| colAddr | output | ADDR_W | Latched column address |
| refStb | output | 1 | One-cycle pulse: a row was refreshed |
| refRow | output | ADDR_W | Row refreshed with the last pulse |
| protoErr | output | 1 | Early column-strobe release |

## Verification
The checks assume the strobes are already synchronous to `clk`, and that each level lasts at least one sample, since a pulse shorter than a clock period is never seen. They also assume write and output enable follow the device rules: output enable is not used to read during a write. The stimulus moves the strobes only at falling clock edges and holds every level for whole cycles. It changes one strobe group per step, except where a simultaneous change is itself the case under test, such as all strobes rising together.

// File: rtl/dcasPkg.sv
package dcasPkg;

  localparam int NUM_TYPES = 9;
  localparam int NUM_LANES = 2;

  localparam int CT_STANDBY    = 0;
  localparam int CT_READ_WORD  = 1;
  localparam int CT_READ_BYTE  = 2;
  localparam int CT_WRITE_WORD = 3;
  localparam int CT_WRITE_BYTE = 4;
  localparam int CT_READ_WRITE = 5;
  localparam int CT_HIDDEN     = 6;
  localparam int CT_ROW_ONLY   = 7;
  localparam int CT_CBR        = 8;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_ROW,
    MODE_ACCESS,
    MODE_CBR,
    MODE_HIDDEN
  } dcasMode_e;

  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic cbrStep;
  } dcasStrobes_t;

endpackage

// File: rtl/dcasCtrl.sv
module dcasCtrl
  import dcasPkg::*;
#(
  parameter int MIN_RAS_ACT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rasN,
  input  logic                  casLoN,
  input  logic                  casHiN,
  input  logic                  weN,
  input  logic                  oeN,
  output dcasStrobes_t          strobes,
  output logic [NUM_TYPES-1:0]  cycleType,
  output logic [NUM_LANES-1:0]  laneOe,
  output logic [NUM_LANES-1:0]  laneWe,
  output logic                  protoErr
);

  localparam int CNT_W = $clog2(MIN_RAS_ACT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_RAS_ACT);
  localparam logic [CNT_W-1:0] CNT_LATE = CNT_W'(MIN_RAS_ACT - 1);

  logic rasActQ, casActQ, weQ, holdQ, rwQ;
  logic [CNT_W-1:0] cntQ, cntNext;
  dcasMode_e modeQ, modeNext;

  logic rasAct, casAct, rasFall, rasRise, casFall, casRise;
  logic holdNext, rwNext, errNext, wordSel;
  logic [NUM_LANES-1:0] laneSel, oeNext, weNext;
  logic [NUM_TYPES-1:0] typeNext;

  assign rasAct  = ~rasN;
  assign casAct  = ~casLoN | ~casHiN;
  assign rasFall = rasAct & ~rasActQ;
  assign rasRise = ~rasAct & rasActQ;
  assign casFall = casAct & ~casActQ;
  assign casRise = ~casAct & casActQ;
  assign laneSel = {~casHiN, ~casLoN};
  assign wordSel = &laneSel;

  always_comb begin
    modeNext = modeQ;
    if (!rasAct)
      modeNext = MODE_IDLE;
    else if (rasFall)
      modeNext = casAct ? (holdQ ? MODE_HIDDEN : MODE_CBR) : MODE_ROW;
    else if (modeQ == MODE_ROW && casFall)
      modeNext = MODE_ACCESS;
  end

  assign holdNext = casAct & (holdQ | (rasRise & (modeQ == MODE_ACCESS)));
  assign rwNext   = (modeNext == MODE_ACCESS) & casAct & ~casFall & (rwQ | (~weN & weQ));
  assign errNext  = casRise & rasAct & (modeQ == MODE_ACCESS) & (cntQ < CNT_LATE);
  assign cntNext  = !rasAct ? '0 : ((cntQ == CNT_MAX) ? cntQ : cntQ + 1'b1);

  assign strobes.latchRow = rasFall & ~casAct;
  assign strobes.latchCol = casFall & (modeNext == MODE_ACCESS);
  assign strobes.cbrStep  = rasFall & casAct;

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    assign oeNext[lane] = laneSel[lane] & ~oeN & weN &
                          ((modeNext == MODE_ACCESS) | holdNext);
    assign weNext[lane] = laneSel[lane] & ~weN & (modeNext == MODE_ACCESS);
  end

  always_comb begin
    typeNext = '0;
    unique case (modeNext)
      MODE_ACCESS: begin
        if (!casAct)    typeNext[CT_ROW_ONLY]   = 1'b1;
        else if (rwNext) typeNext[CT_READ_WRITE] = 1'b1;
        else if (!weN)  typeNext[wordSel ? CT_WRITE_WORD : CT_WRITE_BYTE] = 1'b1;
        else            typeNext[wordSel ? CT_READ_WORD : CT_READ_BYTE]   = 1'b1;
      end
      MODE_ROW:    typeNext[CT_ROW_ONLY] = 1'b1;
      MODE_CBR:    typeNext[CT_CBR]      = 1'b1;
      MODE_HIDDEN: typeNext[CT_HIDDEN]   = 1'b1;
      default: begin
        if (holdNext)    typeNext[CT_HIDDEN]  = 1'b1;
        else if (casAct) typeNext[CT_CBR]     = 1'b1;
        else             typeNext[CT_STANDBY] = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasActQ   <= 1'b0;
      casActQ   <= 1'b0;
      weQ       <= 1'b1;
      holdQ     <= 1'b0;
      rwQ       <= 1'b0;
      cntQ      <= '0;
      modeQ     <= MODE_IDLE;
      cycleType <= NUM_TYPES'(1) << CT_STANDBY;
      laneOe    <= '0;
      laneWe    <= '0;
      protoErr  <= 1'b0;
    end else begin
      rasActQ   <= rasAct;
      casActQ   <= casAct;
      weQ       <= weN;
      holdQ     <= holdNext;
      rwQ       <= rwNext;
      cntQ      <= cntNext;
      modeQ     <= modeNext;
      cycleType <= typeNext;
      laneOe    <= oeNext;
      laneWe    <= weNext;
      protoErr  <= errNext;
    end
  end

  assert_onehot_type_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cycleType) == 1);

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycleType[CT_STANDBY] |-> (laneOe == '0 && laneWe == '0));

  assert_write_type_R4: assert property (@(posedge clk) disable iff (!rstN)
    (laneWe != '0) |-> (cycleType[CT_WRITE_WORD] | cycleType[CT_WRITE_BYTE] |
                        cycleType[CT_READ_WRITE]));

  assert_cbr_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    cycleType[CT_CBR] |-> (laneOe == '0 && laneWe == '0));

  assert_err_on_cas_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (!casActQ && $past(casActQ)));

endmodule

// File: rtl/dcasPath.sv
module dcasPath
  import dcasPkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int REF_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  dcasStrobes_t      strobes,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              refStb,
  output logic [ADDR_W-1:0] refRow
);

  logic [REF_W-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAddr <= '0;
      colAddr <= '0;
      refStb  <= 1'b0;
      refRow  <= '0;
      refCnt  <= '0;
    end else begin
      refStb <= strobes.latchRow | strobes.cbrStep;
      if (strobes.latchRow) begin
        rowAddr <= addr;
        refRow  <= addr;
      end
      if (strobes.latchCol)
        colAddr <= addr;
      if (strobes.cbrStep) begin
        refRow <= ADDR_W'(refCnt);
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  assert_cbr_counter_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cbrStep |=> (refCnt == REF_W'($past(refCnt) + 1'b1)) && refStb);

  assert_row_refresh_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchRow |=> (refStb && refRow == $past(addr) && rowAddr == $past(addr)));

endmodule

// File: rtl/dcasDecoder.sv
module dcasDecoder
  import dcasPkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int REF_W       = 9,
  parameter int MIN_RAS_ACT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casLoN,
  input  logic              casHiN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  output logic [8:0]        cycleType,
  output logic [1:0]        laneOe,
  output logic [1:0]        laneWe,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              refStb,
  output logic [ADDR_W-1:0] refRow,
  output logic              protoErr
);

  dcasStrobes_t strobes;

  dcasCtrl #(.MIN_RAS_ACT(MIN_RAS_ACT)) uCtrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casLoN(casLoN), .casHiN(casHiN),
    .weN(weN), .oeN(oeN), .strobes(strobes), .cycleType(cycleType),
    .laneOe(laneOe), .laneWe(laneWe), .protoErr(protoErr)
  );

  dcasPath #(.ADDR_W(ADDR_W), .REF_W(REF_W)) uPath (
    .clk(clk), .rstN(rstN), .addr(addr), .strobes(strobes),
    .rowAddr(rowAddr), .colAddr(colAddr), .refStb(refStb), .refRow(refRow)
  );

endmodule

// File: tb/tb_dcasDecoder.sv
`timescale 1ns/1ps
module tb_dcasDecoder;

  localparam int T_SB = 0, T_RW_ = 1, T_RB = 2, T_WW = 3, T_WB = 4;
  localparam int T_RMW = 5, T_HID = 6, T_RO = 7, T_CBR = 8;

  typedef struct {
    logic [8:0] typ;
    logic [1:0] oe;
    logic [1:0] we;
    logic       err;
    logic       ref_;
    logic [8:0] refRowE;
    logic       chkAddr;
    logic [8:0] row;
    logic [8:0] col;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casLoN = 1'b1, casHiN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [8:0] addr = '0;
  logic [8:0] cycleType;
  logic [1:0] laneOe, laneWe;
  logic [8:0] rowAddr, colAddr, refRow;
  logic refStb, protoErr;

  int checks = 0;
  int failures = 0;
  expItem_t q[$];
  logic pendAddr = 1'b0;
  logic [8:0] pendRow = '0, pendCol = '0;

  always #4 clk = ~clk;

  dcasDecoder dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casLoN(casLoN), .casHiN(casHiN),
    .weN(weN), .oeN(oeN), .addr(addr), .cycleType(cycleType), .laneOe(laneOe),
    .laneWe(laneWe), .rowAddr(rowAddr), .colAddr(colAddr), .refStb(refStb),
    .refRow(refRow), .protoErr(protoErr)
  );

  task automatic wantAddr(input logic [8:0] r, input logic [8:0] c);
    pendAddr = 1'b1; pendRow = r; pendCol = c;
  endtask

  task automatic step(input logic r, cl, ch, w, o, input logic [8:0] a,
                      input int t, input logic [1:0] eOe, eWe,
                      input logic eErr, eRef, input logic [8:0] eRow,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    rasN = r; casLoN = cl; casHiN = ch; weN = w; oeN = o; addr = a;
    it.typ = 9'(1) << t; it.oe = eOe; it.we = eWe; it.err = eErr;
    it.ref_ = eRef; it.refRowE = eRow; it.chkAddr = pendAddr;
    it.row = pendRow; it.col = pendCol; it.tag = tag;
    pendAddr = 1'b0;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && q.size() > 0) begin
      expItem_t it;
      logic bad;
      it = q.pop_front();
      bad = (cycleType !== it.typ) || (laneOe !== it.oe) || (laneWe !== it.we) ||
            (protoErr !== it.err) || (refStb !== it.ref_) ||
            (it.ref_ && refRow !== it.refRowE) ||
            (it.chkAddr && (rowAddr !== it.row || colAddr !== it.col));
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s: act type=%b oe=%b we=%b err=%b ref=%b refRow=%h row=%h col=%h exp type=%b oe=%b we=%b err=%b ref=%b refRow=%h row=%h col=%h",
                 it.tag, cycleType, laneOe, laneWe, protoErr, refStb, refRow, rowAddr,
                 colAddr, it.typ, it.oe, it.we, it.err, it.ref_, it.refRowE, it.row, it.col);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2: act running exp finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cycleType !== 9'b000000001 || laneOe !== 2'b00 || laneWe !== 2'b00 ||
        protoErr !== 1'b0 || refStb !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: act type=%b oe=%b we=%b exp type=000000001 oe=00 we=00",
               cycleType, laneOe, laneWe);
    end
    rstN = 1'b1;

    // R2 standby, R6 row open, R3 word read, R10 release on time
    step(1,1,1,1,1, 9'h000, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 standby");
    step(0,1,1,1,0, 9'h055, T_RO,  2'b00, 2'b00, 0, 1, 9'h055, "R6 row-only open");
    wantAddr(9'h055, 9'h0A3);
    step(0,0,0,1,0, 9'h0A3, T_RW_, 2'b11, 2'b00, 0, 0, 9'h000, "R3 word read");
    step(0,0,0,1,0, 9'h1EE, T_RW_, 2'b11, 2'b00, 0, 0, 9'h000, "R3 word read hold");
    step(0,1,1,1,0, 9'h1EE, T_RO,  2'b00, 2'b00, 0, 0, 9'h000, "R10 release at limit");
    step(1,1,1,1,1, 9'h1EE, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 back to standby");

    // R3 byte read, OE gating, R5 strobe union
    step(0,1,1,1,1, 9'h101, T_RO,  2'b00, 2'b00, 0, 1, 9'h101, "R6 row latch");
    step(0,0,1,1,1, 9'h042, T_RB,  2'b00, 2'b00, 0, 0, 9'h000, "R3 byte read oe high");
    step(0,0,1,1,0, 9'h042, T_RB,  2'b01, 2'b00, 0, 0, 9'h000, "R3 lower byte read");
    wantAddr(9'h101, 9'h042);
    step(0,0,0,1,0, 9'h0FF, T_RW_, 2'b11, 2'b00, 0, 0, 9'h000, "R5 second strobe no latch");
    step(0,1,0,1,0, 9'h0FF, T_RB,  2'b10, 2'b00, 0, 0, 9'h000, "R5 union still active");
    step(1,1,1,1,1, 9'h0FF, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 standby");

    // R4 upper byte early write, OE ignored, R10 early release
    step(0,1,1,1,1, 9'h0F0, T_RO,  2'b00, 2'b00, 0, 1, 9'h0F0, "R6 row latch");
    step(0,1,0,0,0, 9'h011, T_WB,  2'b00, 2'b10, 0, 0, 9'h000, "R4 upper byte write oe ignored");
    step(0,1,1,0,0, 9'h011, T_RO,  2'b00, 2'b00, 1, 0, 9'h000, "R10 early release");
    step(1,1,1,1,1, 9'h011, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R10 pulse one cycle");

    // R4 word write, page mode read, R9 read-write
    step(0,1,1,1,1, 9'h1FF, T_RO,  2'b00, 2'b00, 0, 1, 9'h1FF, "R6 row latch");
    step(0,0,0,0,1, 9'h020, T_WW,  2'b00, 2'b11, 0, 0, 9'h000, "R4 word write");
    step(0,0,0,0,1, 9'h020, T_WW,  2'b00, 2'b11, 0, 0, 9'h000, "R4 word write hold");
    step(0,1,1,1,1, 9'h020, T_RO,  2'b00, 2'b00, 0, 0, 9'h000, "R10 no error at limit");
    wantAddr(9'h1FF, 9'h00C);
    step(0,0,0,1,0, 9'h00C, T_RW_, 2'b11, 2'b00, 0, 0, 9'h000, "R5 page column latch");
    step(0,0,0,0,0, 9'h00C, T_RMW, 2'b00, 2'b11, 0, 0, 9'h000, "R9 read-write");
    step(1,1,1,1,1, 9'h00C, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 joint release");

    // R7 column-first refresh
    step(1,0,1,1,1, 9'h1EE, T_CBR, 2'b00, 2'b00, 0, 0, 9'h000, "R7 column strobe first");
    step(0,0,1,1,1, 9'h1EE, T_CBR, 2'b00, 2'b00, 0, 1, 9'h000, "R7 counter row 0");
    wantAddr(9'h1FF, 9'h00C);
    step(0,0,1,1,0, 9'h1EE, T_CBR, 2'b00, 2'b00, 0, 0, 9'h000, "R7 addresses kept");
    step(1,1,1,1,1, 9'h1EE, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 standby");
    step(1,1,0,1,1, 9'h1EE, T_CBR, 2'b00, 2'b00, 0, 0, 9'h000, "R7 upper strobe first");
    step(0,1,0,1,1, 9'h1EE, T_CBR, 2'b00, 2'b00, 0, 1, 9'h001, "R7 counter row 1");
    step(1,1,1,1,1, 9'h1EE, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 standby");

    // R8 hidden refresh
    step(0,1,1,1,0, 9'h033, T_RO,  2'b00, 2'b00, 0, 1, 9'h033, "R6 row latch");
    step(0,0,0,1,0, 9'h0AA, T_RW_, 2'b11, 2'b00, 0, 0, 9'h000, "R3 read before hidden");
    step(0,0,0,1,0, 9'h1EE, T_RW_, 2'b11, 2'b00, 0, 0, 9'h000, "R3 read hold");
    step(1,0,0,1,0, 9'h1EE, T_HID, 2'b11, 2'b00, 0, 0, 9'h000, "R8 row strobe up data held");
    step(0,0,0,1,0, 9'h1EE, T_HID, 2'b11, 2'b00, 0, 1, 9'h002, "R8 hidden refresh row 2");
    wantAddr(9'h033, 9'h0AA);
    step(1,0,0,1,0, 9'h1EE, T_HID, 2'b11, 2'b00, 0, 0, 9'h000, "R8 addresses kept");
    step(1,1,1,1,1, 9'h1EE, T_SB,  2'b00, 2'b00, 0, 0, 9'h000, "R2 end of hidden");

    @(negedge clk);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule